// File: doc/BRIEF.md
# Address Hit Trace Filter

This block watches a stream of 24-bit bus addresses, each marked by a valid strobe, and decides which of them to report. A host first loads an option mask, a start address, an end address, a hits-per-packet value and a packet count, then pulses `start`. From that point qualified hits go into a hit buffer. When the buffer holds a full packet's worth, the packet is sent as a byte stream over a valid/ready handshake.

The option mask turns several rules on or off:
- an inclusive address window;
- suppression of back-to-back repeats;
- a start trigger that arms reporting;
- an end trigger that stops it;
- addresses reported relative to the start address;
- a report width of one, two or three bytes.

The session closes with an acknowledge byte 0x4F. This happens after the configured packet count in one-shot mode, after a hard stop (the current address finishes first), or after a soft stop or end trigger (the current packet finishes first).

Top module: `addr_trace_filter`

## Requirements
- R1: After reset `out_valid`, `busy` and `overflow` are 0.
- R2: With option bit 1 set, only hits whose address A satisfies start <= A <= end (unsigned) are reported.
- R3: With option bit 2 set, a hit whose full 24-bit address equals the hit seen on the immediately preceding valid cycle of the session is not reported. The same address after a different one is reported.
- R4: With option bit 3 set, no hit is reported until a hit equal to the start address arrives. That trigger hit is itself not reported, and later hits are.
- R5: With option bit 4 set (and reporting armed), a hit equal to the end address is not reported and acts as a soft stop (R11).
- R6: With option bit 5 set, the reported value is (hit − start) modulo 2^24.
- R7: Option bits 7:6 choose the report width: 1 gives the low byte only, 2 gives bits 15:0 as two bytes most significant first, and 0 or 3 gives all 24 bits as three bytes most significant first.
- R8: A packet is sent only once P qualified hits are buffered. P is the hits-per-packet value, with 0 read as 1 and values above the buffer depth read as the depth. The P hits are then sent back to back in arrival order.
- R9: With option bit 0 set, the acknowledge byte 0x4F follows the last byte of the configured number of packets and the block goes idle. With option bit 0 clear, packets continue until a stop.
- R10: A hard stop lets the bytes of the address currently being sent finish, then emits 0x4F and goes idle. Buffered hits that have not been sent are discarded.
- R11: A soft stop lets the current packet finish, then emits 0x4F and goes idle. No hit arriving after a stop is reported.
- R12: A qualified hit that arrives while the buffer is full is dropped and sets `overflow`. The flag stays set until the next accepted `start`.
- R13: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` do not change.
- R14: Configuration is sampled when `start` is accepted. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a session (accepted when not busy) |
| opt_mask | input | 8 | Option mask |
| addr_lo | input | 24 | Start address (window low, start trigger, relative base) |
| addr_hi | input | 24 | End address (window high, end trigger) |
| hits_per_pkt | input | 8 | Hits per packet |
| pkt_count | input | 8 | Packets per session in one-shot mode |
| hit_valid | input | 1 | Hit strobe |
| hit_addr | input | 24 | Hit address |
| hard_stop | input | 1 | Stop after the current address |
| soft_stop | input | 1 | Stop after the current packet |
| out_data | output | 8 | Report byte |
| out_valid | output | 1 | Report byte valid |
| out_ready | input | 1 | Consumer ready |
| overflow | output | 1 | Sticky buffer overflow flag |
| busy | output | 1 | Session running or byte still pending |

## Verification
The assertions check the following on every cycle:
- the output holds steady while it is stalled;
- the overflow flag stays sticky;
- the buffer is never written when full or read when empty;
- a packet in flight always has buffered hits behind it;
- no hit is captured outside a session;
- a reported hit always satisfies the window, repeat and trigger rules.

Only the bench scenarios can show the rest: the exact byte sequences for each width and relative setting, the packet gating, and where the acknowledge byte lands after hard stops, soft stops, end triggers and the packet limit.

// File: rtl/trace_filter_pkg.sv
`timescale 1ns/1ps
package trace_filter_pkg;
  localparam int ADDR_W = 24;
  localparam logic [7:0] ACK_BYTE = 8'h4F;

  localparam int OPT_ONESHOT   = 0;
  localparam int OPT_WINDOW    = 1;
  localparam int OPT_NODUP     = 2;
  localparam int OPT_STARTTRIG = 3;
  localparam int OPT_ENDTRIG   = 4;
  localparam int OPT_REL       = 5;

  typedef struct packed {
    logic [7:0]        opt;
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
    logic [7:0]        hpp;
    logic [7:0]        limit;
  } trace_cfg_t;

  // Number of bytes per reported address, chosen by option bits 7:6.
  function automatic logic [1:0] report_bytes(logic [1:0] sel);
    case (sel)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/hit_fifo.sv
`timescale 1ns/1ps
module hit_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 24,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  p_push_not_full_r12: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  p_pop_not_empty_r8: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/hit_qualifier.sv
`timescale 1ns/1ps
module hit_qualifier
  import trace_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_acc,
  input  logic              run,
  input  logic              accepting,
  input  logic              win_en,
  input  logic              nodup_en,
  input  logic              strig_en,
  input  logic              etrig_en,
  input  logic              rel_en,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic              hit_valid,
  input  logic [ADDR_W-1:0] hit_addr,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_addr,
  output logic              end_hit
);
  logic              triggered, prev_vld;
  logic [ADDR_W-1:0] prev_addr;
  logic              armed, end_match, win_ok, dup, seen;

  always_comb begin
    seen      = accepting && hit_valid;
    armed     = !strig_en || triggered;
    end_match = etrig_en && armed && (hit_addr == hi);
    win_ok    = !win_en || ((hit_addr >= lo) && (hit_addr <= hi));
    dup       = nodup_en && prev_vld && (hit_addr == prev_addr);
    q_valid   = seen && armed && !end_match && win_ok && !dup;
    end_hit   = seen && end_match;
    q_addr    = rel_en ? (hit_addr - lo) : hit_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      triggered <= 1'b0;
      prev_vld  <= 1'b0;
      prev_addr <= '0;
    end else if (start_acc) begin
      triggered <= 1'b0;
      prev_vld  <= 1'b0;
    end else begin
      if (run && hit_valid) begin
        prev_vld  <= 1'b1;
        prev_addr <= hit_addr;
      end
      if (seen && strig_en && (hit_addr == lo)) triggered <= 1'b1;
    end
  end

  p_window_r2: assert property (@(posedge clk) disable iff (rst)
    (q_valid && win_en) |-> ((hit_addr >= lo) && (hit_addr <= hi)));
  p_no_repeat_r3: assert property (@(posedge clk) disable iff (rst)
    (q_valid && nodup_en && prev_vld) |-> (hit_addr != prev_addr));
  p_armed_before_report_r4: assert property (@(posedge clk) disable iff (rst)
    (q_valid && strig_en) |-> triggered);
endmodule

// File: rtl/pkt_sender.sv
`timescale 1ns/1ps
module pkt_sender
  import trace_filter_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_acc,
  input  logic              run,
  input  logic              hard_q,
  input  logic              soft_q,
  input  logic [1:0]        width_sel,
  input  logic              one_shot,
  input  logic [7:0]        hpp,
  input  logic [7:0]        limit,
  input  logic              fifo_empty,
  input  logic [CW-1:0]     fifo_count,
  input  logic [ADDR_W-1:0] fifo_rdata,
  output logic              pop,
  output logic              sess_end,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  logic [1:0]        bytes_left, w;
  logic [7:0]        hits_left, pkts_done, hits_base;
  logic              in_pkt;
  logic [ADDR_W-1:0] shreg, word;
  logic              ld, between, limit_hit, do_ack, do_load, enough;

  always_comb begin
    ld        = !out_valid || out_ready;
    w         = report_bytes(width_sel);
    between   = ld && run && (bytes_left == 2'd0);
    limit_hit = one_shot && (pkts_done >= limit);
    enough    = (32'(fifo_count) >= 32'(hpp));
    do_ack    = between && (hard_q || (!in_pkt && (soft_q || limit_hit)));
    do_load   = between && !do_ack && (in_pkt ? !fifo_empty : enough);
    pop       = do_load;
    sess_end  = do_ack;
    hits_base = in_pkt ? hits_left : hpp;
    case (w)
      2'd1:    word = {fifo_rdata[7:0], 16'h0};
      2'd2:    word = {fifo_rdata[15:0], 8'h0};
      default: word = fifo_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      bytes_left <= '0;
      hits_left  <= '0;
      pkts_done  <= '0;
      in_pkt     <= 1'b0;
      shreg      <= '0;
    end else if (start_acc) begin
      bytes_left <= '0;
      hits_left  <= '0;
      pkts_done  <= '0;
      in_pkt     <= 1'b0;
    end else if (ld) begin
      if (bytes_left != 2'd0) begin
        out_data   <= shreg[ADDR_W-1 -: 8];
        shreg      <= shreg << 8;
        out_valid  <= 1'b1;
        bytes_left <= bytes_left - 2'd1;
        if (bytes_left == 2'd1) begin
          hits_left <= hits_left - 8'd1;
          if (hits_left == 8'd1) begin
            in_pkt    <= 1'b0;
            pkts_done <= pkts_done + 8'd1;
          end
        end
      end else if (do_ack) begin
        out_data  <= ACK_BYTE;
        out_valid <= 1'b1;
      end else if (do_load) begin
        out_data   <= word[ADDR_W-1 -: 8];
        shreg      <= word << 8;
        out_valid  <= 1'b1;
        bytes_left <= w - 2'd1;
        in_pkt     <= 1'b1;
        hits_left  <= hits_base;
        if (w == 2'd1) begin
          hits_left <= hits_base - 8'd1;
          if (hits_base == 8'd1) begin
            in_pkt    <= 1'b0;
            pkts_done <= pkts_done + 8'd1;
          end
        end
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  p_hold_stall_r13: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_pkt_backed_r8: assert property (@(posedge clk) disable iff (rst)
    (between && in_pkt && !hard_q) |-> !fifo_empty);
endmodule

// File: rtl/addr_trace_filter.sv
`timescale 1ns/1ps
module addr_trace_filter
  import trace_filter_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opt_mask,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [ADDR_W-1:0] addr_hi,
  input  logic [7:0]        hits_per_pkt,
  input  logic [7:0]        pkt_count,
  input  logic              hit_valid,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic              hard_stop,
  input  logic              soft_stop,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              overflow,
  output logic              busy
);
  trace_cfg_t        cfg;
  logic              run, hard_q, soft_q, start_acc, accepting;
  logic              q_valid, end_hit, push, pop, sess_end;
  logic              fifo_full, fifo_empty;
  logic [ADDR_W-1:0] q_addr, fifo_rdata;
  logic [CW-1:0]     fifo_count;
  logic [7:0]        hpp_eff;

  assign busy      = run || out_valid;
  assign start_acc = start && !busy;
  assign accepting = run && !hard_q && !soft_q;
  assign push      = q_valid && !fifo_full;
  assign hpp_eff   = (hits_per_pkt == 8'd0)      ? 8'd1 :
                     (hits_per_pkt > 8'(DEPTH)) ? 8'(DEPTH) : hits_per_pkt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      run      <= 1'b0;
      hard_q   <= 1'b0;
      soft_q   <= 1'b0;
      overflow <= 1'b0;
    end else if (start_acc) begin
      cfg      <= '{opt: opt_mask, lo: addr_lo, hi: addr_hi,
                    hpp: hpp_eff, limit: pkt_count};
      run      <= 1'b1;
      hard_q   <= 1'b0;
      soft_q   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (sess_end) run <= 1'b0;
      if (run && hard_stop) hard_q <= 1'b1;
      if (run && (soft_stop || end_hit)) soft_q <= 1'b1;
      if (q_valid && fifo_full) overflow <= 1'b1;
    end
  end

  hit_qualifier u_qual (
    .clk       (clk),
    .rst       (rst),
    .start_acc (start_acc),
    .run       (run),
    .accepting (accepting),
    .win_en    (cfg.opt[OPT_WINDOW]),
    .nodup_en  (cfg.opt[OPT_NODUP]),
    .strig_en  (cfg.opt[OPT_STARTTRIG]),
    .etrig_en  (cfg.opt[OPT_ENDTRIG]),
    .rel_en    (cfg.opt[OPT_REL]),
    .lo        (cfg.lo),
    .hi        (cfg.hi),
    .hit_valid (hit_valid),
    .hit_addr  (hit_addr),
    .q_valid   (q_valid),
    .q_addr    (q_addr),
    .end_hit   (end_hit)
  );

  hit_fifo #(.DEPTH(DEPTH), .W(ADDR_W)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (start_acc),
    .push  (push),
    .wdata (q_addr),
    .pop   (pop),
    .rdata (fifo_rdata),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  pkt_sender #(.CW(CW)) u_send (
    .clk        (clk),
    .rst        (rst),
    .start_acc  (start_acc),
    .run        (run),
    .hard_q     (hard_q),
    .soft_q     (soft_q),
    .width_sel  (cfg.opt[7:6]),
    .one_shot   (cfg.opt[OPT_ONESHOT]),
    .hpp        (cfg.hpp),
    .limit      (cfg.limit),
    .fifo_empty (fifo_empty),
    .fifo_count (fifo_count),
    .fifo_rdata (fifo_rdata),
    .pop        (pop),
    .sess_end   (sess_end),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready)
  );

  p_overflow_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (overflow && !start_acc) |=> overflow);
  p_idle_no_push_r14: assert property (@(posedge clk) disable iff (rst)
    !run |-> !push);
  p_stop_blocks_push_r11: assert property (@(posedge clk) disable iff (rst)
    (hard_q || soft_q) |-> !push);
endmodule

// File: tb/addr_trace_filter_bench.sv
`timescale 1ns/1ps
module addr_trace_filter_bench;
  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0]  opt = '0, hpp = 8'd1, lim = 8'd1;
  logic [23:0] lo = '0, hi = '0, ha = '0;
  logic        hv = 1'b0, hs = 1'b0, ss = 1'b0, ordy = 1'b1;
  logic [7:0]  od;
  logic        ov, ovf, busy;

  always #2 clk = ~clk;

  addr_trace_filter u_addr_trace_filter (
    .clk(clk), .rst(rst), .start(start), .opt_mask(opt), .addr_lo(lo),
    .addr_hi(hi), .hits_per_pkt(hpp), .pkt_count(lim), .hit_valid(hv),
    .hit_addr(ha), .hard_stop(hs), .soft_stop(ss), .out_data(od),
    .out_valid(ov), .out_ready(ordy), .overflow(ovf), .busy(busy)
  );

  int checks = 0, fails = 0;
  logic [7:0] cap [0:63];
  logic [7:0] expb[0:63];
  int ncap = 0, nexp = 0;

  // fields: opt | start | end | hit | nbytes | expected value
  localparam int NV = 11;
  localparam logic [105:0] VEC [0:NV-1] = '{
    {8'h01, 24'h000000, 24'h000000, 24'h123456, 2'd3, 24'h123456},
    {8'h41, 24'h000000, 24'h000000, 24'h123456, 2'd1, 24'h000056},
    {8'h81, 24'h000000, 24'h000000, 24'h123456, 2'd2, 24'h003456},
    {8'hC1, 24'h000000, 24'h000000, 24'h123456, 2'd3, 24'h123456},
    {8'h03, 24'h001000, 24'h002000, 24'h001000, 2'd3, 24'h001000},
    {8'h03, 24'h001000, 24'h002000, 24'h002000, 2'd3, 24'h002000},
    {8'h03, 24'h001000, 24'h002000, 24'h002001, 2'd0, 24'h000000},
    {8'h03, 24'h001000, 24'h002000, 24'h000FFF, 2'd0, 24'h000000},
    {8'h21, 24'h100000, 24'h000000, 24'h100234, 2'd3, 24'h000234},
    {8'h21, 24'h000010, 24'h000000, 24'h000005, 2'd3, 24'hFFFFF5},
    {8'hA1, 24'h001000, 24'h000000, 24'h0034AB, 2'd2, 24'h0024AB}
  };

  always @(negedge clk) begin
    if (!rst && ov && ordy && ncap < 64) begin
      cap[ncap] = od;
      ncap++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic begin_session(input logic [7:0] o, input logic [23:0] l,
                               input logic [23:0] h, input logic [7:0] p,
                               input logic [7:0] m);
    opt = o; lo = l; hi = h; hpp = p; lim = m;
    ncap = 0; nexp = 0;
    start = 1'b1; tick(1); start = 1'b0;
  endtask

  task automatic hit(input logic [23:0] a);
    hv = 1'b1; ha = a; tick(1); hv = 1'b0; tick(4);
  endtask

  task automatic pulse_hard();
    hs = 1'b1; tick(1); hs = 1'b0;
  endtask

  task automatic pulse_soft();
    ss = 1'b1; tick(1); ss = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    tick(1);
  endtask

  task automatic expect_byte(input logic [7:0] b);
    expb[nexp] = b; nexp++;
  endtask

  task automatic compare(input string tag);
    bit ok;
    string sa, se;
    ok = (ncap == nexp);
    sa = ""; se = "";
    for (int k = 0; k < ncap; k++) sa = {sa, $sformatf("%02h ", cap[k])};
    for (int k = 0; k < nexp; k++) begin
      se = {se, $sformatf("%02h ", expb[k])};
      if (k < ncap && cap[k] !== expb[k]) ok = 1'b0;
    end
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual [%s] expected [%s]", tag, sa, se);
    end
  endtask

  task automatic check1(input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    logic [105:0] row;
    logic [1:0]   nb;
    logic [23:0]  val;
    tick(5);
    // R1 reset state
    check1("R1 out_valid in reset", 32'(ov), 0);
    rst = 1'b0;
    tick(2);
    check1("R1 busy after reset", 32'(busy), 0);
    check1("R1 overflow after reset", 32'(ovf), 0);
    check1("R1 out_valid after reset", 32'(ov), 0);

    // Table walk: R2 window, R6 relative, R7 width (one hit, one-shot, 1 packet)
    for (int i = 0; i < NV; i++) begin
      row = VEC[i];
      nb  = row[25:24];
      val = row[23:0];
      begin_session(row[105:98], row[97:74], row[73:50], 8'd1, 8'd1);
      hit(row[49:26]);
      tick(20);
      pulse_hard();
      wait_idle();
      for (int k = 0; k < int'(nb); k++) expect_byte(8'(val >> (8 * (int'(nb) - 1 - k))));
      expect_byte(8'h4F);
      compare($sformatf("R2/R6/R7 vector %0d", i));
    end

    // R3 repeat suppression on full 24-bit address
    begin_session(8'h45, 24'h0, 24'h0, 8'd4, 8'd1);
    hit(24'h000011); hit(24'h000011); hit(24'h000022);
    hit(24'h000011); hit(24'h010011);
    wait_idle();
    expect_byte(8'h11); expect_byte(8'h22); expect_byte(8'h11);
    expect_byte(8'h11); expect_byte(8'h4F);
    compare("R3 repeat suppression");

    // R4 start trigger
    begin_session(8'h49, 24'h000050, 24'h0, 8'd2, 8'd1);
    hit(24'h30); hit(24'h50); hit(24'h60); hit(24'h70);
    wait_idle();
    expect_byte(8'h60); expect_byte(8'h70); expect_byte(8'h4F);
    compare("R4 start trigger");

    // R5 end trigger acts as soft stop
    begin_session(8'h50, 24'h0, 24'h000099, 8'd1, 8'd0);
    hit(24'h01); hit(24'h02); hit(24'h99); hit(24'h03);
    wait_idle();
    expect_byte(8'h01); expect_byte(8'h02); expect_byte(8'h4F);
    compare("R5 end trigger");

    // R8 packet waits for full count, streaming continues (R9)
    begin_session(8'h40, 24'h0, 24'h0, 8'd3, 8'd0);
    hit(24'h05); hit(24'h06);
    tick(10);
    check1("R8 no bytes before packet full", 32'(ncap), 0);
    hit(24'h07);
    tick(10);
    expect_byte(8'h05); expect_byte(8'h06); expect_byte(8'h07);
    compare("R8 packet burst");
    check1("R9 streaming still busy", 32'(busy), 1);
    pulse_soft();
    wait_idle();
    expect_byte(8'h4F);
    compare("R11 soft stop between packets");

    // R9 one-shot packet limit
    begin_session(8'h41, 24'h0, 24'h0, 8'd2, 8'd2);
    hit(24'h0A); hit(24'h0B); hit(24'h0C); hit(24'h0D); hit(24'h0E);
    wait_idle();
    expect_byte(8'h0A); expect_byte(8'h0B); expect_byte(8'h0C);
    expect_byte(8'h0D); expect_byte(8'h4F);
    compare("R9 packet limit");

    // R10 hard stop mid-address, R13 stall hold
    begin_session(8'h01, 24'h0, 24'h0, 8'd2, 8'd1);
    ordy = 1'b0;
    hit(24'hA1B2C3); hit(24'hD4E5F6);
    tick(3);
    check1("R13 stalled valid", 32'(ov), 1);
    check1("R13 stalled data", 32'(od), 32'hA1);
    tick(5);
    check1("R13 data held", 32'(od), 32'hA1);
    pulse_hard();
    ordy = 1'b1;
    wait_idle();
    expect_byte(8'hA1); expect_byte(8'hB2); expect_byte(8'hC3); expect_byte(8'h4F);
    compare("R10 hard stop");

    // R11 soft stop mid-packet, later hit ignored
    begin_session(8'h00, 24'h0, 24'h0, 8'd2, 8'd0);
    ordy = 1'b0;
    hit(24'h111111); hit(24'h222222);
    pulse_soft();
    hit(24'h333333);
    tick(3);
    ordy = 1'b1;
    wait_idle();
    for (int k = 0; k < 3; k++) expect_byte(8'h11);
    for (int k = 0; k < 3; k++) expect_byte(8'h22);
    expect_byte(8'h4F);
    compare("R11 soft stop mid packet");

    // R12 overflow
    begin_session(8'h40, 24'h0, 24'h0, 8'd1, 8'd0);
    ordy = 1'b0;
    for (int k = 1; k <= 20; k++) hit(24'(k));
    check1("R12 overflow set", 32'(ovf), 1);
    pulse_hard();
    ordy = 1'b1;
    wait_idle();
    expect_byte(8'h01); expect_byte(8'h4F);
    compare("R12 overflow session bytes");
    check1("R12 overflow sticky after session", 32'(ovf), 1);
    begin_session(8'h40, 24'h0, 24'h0, 8'd1, 8'd0);
    tick(1);
    check1("R12 overflow cleared by start", 32'(ovf), 0);
    pulse_hard();
    wait_idle();

    // R14 start while busy ignored, config sampled at start; hpp 0 read as 1 (R8)
    begin_session(8'h40, 24'h0, 24'h0, 8'd0, 8'd0);
    opt = 8'h80; hpp = 8'd5;
    start = 1'b1; tick(1); start = 1'b0;
    hit(24'h00ABCD);
    tick(5);
    pulse_hard();
    wait_idle();
    expect_byte(8'hCD); expect_byte(8'h4F);
    compare("R14 restart ignored, R8 hpp zero");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule